// File: doc/BRIEF.md
# Display Window Update Sequencer

This block refreshes a rectangular region of a serial display controller's frame memory. A request gives the region's left and top edges and its right and bottom edges, with the right and bottom edges exclusive. The block then emits three commands as a byte stream for a lower serial link layer:

- the column-range command with its four parameters;
- the row-range command with its four parameters;
- the memory-write command.

After the commands it streams the region's pixels. It takes these from a valid/ready pixel source and emits each 16-bit pixel as two bytes. Every output byte carries a data/command flag: 0 for a command byte, 1 for a parameter or pixel byte.

A blank request ignores the given coordinates and covers the whole panel. It writes zeros and draws nothing from the pixel source. Fixed panel offsets, set by parameters, are added to the coordinates before they are split into bytes. An optional swap mode sends the low byte of each pixel first.

Back-pressure rules:

- While `out_valid` is high and `out_ready` is low, the byte and its flag hold steady.
- A pixel is taken only in a cycle where both `pix_valid` and `pix_ready` are high.
- A request is taken only in a cycle where both `req_valid` and `req_ready` are high.
- Only one request is in flight at a time.

Top module: `disp_window_seq`

## Requirements
- R1: While reset is held, `out_valid`, `done`, `err` and `pix_ready` are 0. After reset is released, `req_ready` is 1 while the block is idle.
- R2: A request is accepted only in a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low from acceptance until the cycle in which the `done` or `err` pulse is shown.
- R3: An accepted non-empty request produces, in this order: command 0x2A (flag 0), four parameter bytes, command 0x2B (flag 0), four parameter bytes, then command 0x2C (flag 0). Parameter bytes carry flag 1.
- R4: Each group of four parameter bytes is: start high byte, start low byte, end high byte, end low byte. For columns, start = left + LEFT_OFS and end = right − 1 + LEFT_OFS. For rows, start = top + TOP_OFS and end = bottom − 1 + TOP_OFS. All values are taken modulo 2^16.
- R5: After 0x2C comes a payload of exactly (right − left) × (bottom − top) pixels at two bytes each, all with flag 1. With swap off, the high byte of each pixel is sent first.
- R6: `swap_en` is sampled when a request is accepted. When it is 1, the low byte of every pixel is sent first for that whole request.
- R7: A blank request covers columns 0..PANEL_W−1 and rows 0..PANEL_H−1 and ignores the coordinate inputs. Every payload byte is 0x00, and `pix_ready` stays low for the whole request.
- R8: A non-blank request with right ≤ left or bottom ≤ top (unsigned) raises `err` for one cycle, in the cycle after acceptance. It sends no byte and consumes no pixel.
- R9: `done` pulses for exactly one cycle, in the cycle after the final payload byte is accepted, and at no other time.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_byte` and `out_dc` keep their values into the next cycle.
- R11: `pix_ready` is high only during the payload of a non-blank request. Each accepted pixel is sent exactly once, in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_x0 | input | 16 | Left column (inclusive) |
| req_y0 | input | 16 | Top row (inclusive) |
| req_x1 | input | 16 | Right column (exclusive) |
| req_y1 | input | 16 | Bottom row (exclusive) |
| req_blank | input | 1 | Blank the whole panel instead of the given region |
| swap_en | input | 1 | Send the low pixel byte first |
| pix_valid | input | 1 | Pixel word offered |
| pix_ready | output | 1 | Pixel word taken this cycle if valid |
| pix_data | input | 16 | RGB565 pixel word |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Link layer takes the byte |
| out_byte | output | 8 | Command, parameter or pixel byte |
| out_dc | output | 1 | 0 = command byte, 1 = parameter or pixel byte |
| done | output | 1 | One-cycle pulse after the final payload byte |
| err | output | 1 | One-cycle pulse for a rejected zero-area request |

## Verification
Two things can fall in the same cycle: the hand-over of the final payload byte, and a next request already waiting on `req_valid`. The bench provokes this by issuing a second request while the first is still streaming. It then checks that the second request is taken only once the first one's `done` has appeared, and that the second request's header follows with no stray bytes in between.

A second pair can also coincide: a pixel arriving from the source while the output is stalled. Randomised `out_ready` and `pix_valid` patterns provoke this. Every byte is compared against an arithmetic model of the offsets, the inclusive ends, the byte order and the pixel sequence.

// File: rtl/disp_win_pkg.sv
package disp_win_pkg;
  localparam int COORD_W  = 16;
  localparam int PIX_W    = 16;
  localparam int CNT_W    = 2 * COORD_W;
  localparam int HDR_LAST = 10;

  localparam logic [7:0] CMD_COLUMN = 8'h2A;
  localparam logic [7:0] CMD_ROW    = 8'h2B;
  localparam logic [7:0] CMD_MEMWR  = 8'h2C;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_PIX  = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic [COORD_W-1:0] xs;
    logic [COORD_W-1:0] xe;
    logic [COORD_W-1:0] ys;
    logic [COORD_W-1:0] ye;
  } window_t;
endpackage

// File: rtl/dws_window_calc.sv
module dws_window_calc import disp_win_pkg::*; #(
  parameter int unsigned PANEL_W  = 240,
  parameter int unsigned PANEL_H  = 320,
  parameter int unsigned LEFT_OFS = 0,
  parameter int unsigned TOP_OFS  = 0
) (
  input  logic [COORD_W-1:0] x0,
  input  logic [COORD_W-1:0] y0,
  input  logic [COORD_W-1:0] x1,
  input  logic [COORD_W-1:0] y1,
  input  logic               blank,
  output window_t            win,
  output logic [CNT_W-1:0]   npix,
  output logic               empty
);
  localparam logic [COORD_W-1:0] FULL_W = COORD_W'(PANEL_W);
  localparam logic [COORD_W-1:0] FULL_H = COORD_W'(PANEL_H);
  localparam logic [COORD_W-1:0] OFS_X  = COORD_W'(LEFT_OFS);
  localparam logic [COORD_W-1:0] OFS_Y  = COORD_W'(TOP_OFS);
  localparam logic [COORD_W-1:0] ONE    = COORD_W'(1);

  logic [COORD_W-1:0] ex0, ey0, ex1, ey1;
  logic [COORD_W-1:0] span_x, span_y;
  logic [CNT_W-1:0]   wide_x, wide_y;

  always_comb begin
    if (blank) begin
      ex0 = '0;
      ey0 = '0;
      ex1 = FULL_W;
      ey1 = FULL_H;
    end else begin
      ex0 = x0;
      ey0 = y0;
      ex1 = x1;
      ey1 = y1;
    end
  end

  assign empty  = (ex1 <= ex0) || (ey1 <= ey0);
  assign span_x = ex1 - ex0;
  assign span_y = ey1 - ey0;
  assign wide_x = {{(CNT_W-COORD_W){1'b0}}, span_x};
  assign wide_y = {{(CNT_W-COORD_W){1'b0}}, span_y};
  assign npix   = wide_x * wide_y;

  assign win.xs = ex0 + OFS_X;
  assign win.xe = ex1 - ONE + OFS_X;
  assign win.ys = ey0 + OFS_Y;
  assign win.ye = ey1 - ONE + OFS_Y;
endmodule

// File: rtl/dws_header_gen.sv
module dws_header_gen import disp_win_pkg::*; (
  input  logic [3:0] idx,
  input  window_t    win,
  output logic [7:0] hbyte,
  output logic       hdc
);
  logic               row_grp;
  logic [3:0]         sel;
  logic [COORD_W-1:0] s_val, e_val;

  assign row_grp = (idx > 4'd5);
  assign sel     = row_grp ? (idx - 4'd6) : (idx - 4'd1);
  assign s_val   = row_grp ? win.ys : win.xs;
  assign e_val   = row_grp ? win.ye : win.xe;

  always_comb begin
    hdc = 1'b1;
    case (idx)
      4'd0:  begin hbyte = CMD_COLUMN; hdc = 1'b0; end
      4'd5:  begin hbyte = CMD_ROW;    hdc = 1'b0; end
      4'd10: begin hbyte = CMD_MEMWR;  hdc = 1'b0; end
      default: begin
        case (sel[1:0])
          2'd0:    hbyte = s_val[15:8];
          2'd1:    hbyte = s_val[7:0];
          2'd2:    hbyte = e_val[15:8];
          default: hbyte = e_val[7:0];
        endcase
      end
    endcase
  end
endmodule

// File: rtl/dws_pixel_stage.sv
module dws_pixel_stage import disp_win_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] npix,
  input  logic             blank,
  input  logic             swap,
  input  logic             active,
  input  logic             pix_valid,
  output logic             pix_ready,
  input  logic [PIX_W-1:0] pix_data,
  output logic             byte_valid,
  input  logic             byte_ready,
  output logic [7:0]       byte_out,
  output logic             last_fire
);
  logic [CNT_W-1:0] remaining;
  logic [PIX_W-1:0] hold;
  logic             have, phase, blank_r, swap_r, fire;

  assign pix_ready  = active && !blank_r && !have;
  assign byte_valid = active && (blank_r || have);
  assign byte_out   = blank_r ? 8'h00 :
                      ((phase ^ swap_r) ? hold[7:0] : hold[15:8]);
  assign fire       = byte_valid && byte_ready;
  assign last_fire  = fire && phase && (remaining == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remaining <= '0;
      hold      <= '0;
      have      <= 1'b0;
      phase     <= 1'b0;
      blank_r   <= 1'b0;
      swap_r    <= 1'b0;
    end else if (start) begin
      remaining <= npix;
      have      <= 1'b0;
      phase     <= 1'b0;
      blank_r   <= blank;
      swap_r    <= swap;
    end else begin
      if (pix_valid && pix_ready) begin
        hold  <= pix_data;
        have  <= 1'b1;
        phase <= 1'b0;
      end
      if (fire) begin
        if (!phase) begin
          phase <= 1'b1;
        end else begin
          phase     <= 1'b0;
          have      <= 1'b0;
          remaining <= remaining - CNT_W'(1);
        end
      end
    end
  end

  // R5
  cnt_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (remaining != '0));

  // R11
  pix_byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !byte_ready && !blank_r) |=> (!pix_ready && $stable(hold)));
endmodule

// File: rtl/disp_window_seq.sv
module disp_window_seq import disp_win_pkg::*; #(
  parameter int unsigned PANEL_W  = 240,
  parameter int unsigned PANEL_H  = 320,
  parameter int unsigned LEFT_OFS = 0,
  parameter int unsigned TOP_OFS  = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [15:0]  req_x0,
  input  logic [15:0]  req_y0,
  input  logic [15:0]  req_x1,
  input  logic [15:0]  req_y1,
  input  logic         req_blank,
  input  logic         swap_en,
  input  logic         pix_valid,
  output logic         pix_ready,
  input  logic [15:0]  pix_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [7:0]   out_byte,
  output logic         out_dc,
  output logic         done,
  output logic         err
);
  seq_state_e       state;
  logic [3:0]       hdr_idx;
  window_t          win_c, win_r;
  logic [CNT_W-1:0] npix_c;
  logic             empty_c, accept, start;
  logic [7:0]       hdr_byte, pix_byte;
  logic             hdr_dc, pix_bvalid, last_fire, in_hdr, in_pix;
  logic             done_r, err_r;

  dws_window_calc #(
    .PANEL_W(PANEL_W), .PANEL_H(PANEL_H),
    .LEFT_OFS(LEFT_OFS), .TOP_OFS(TOP_OFS)
  ) u_calc (
    .x0(req_x0), .y0(req_y0), .x1(req_x1), .y1(req_y1),
    .blank(req_blank), .win(win_c), .npix(npix_c), .empty(empty_c)
  );

  dws_header_gen u_hdr (
    .idx(hdr_idx), .win(win_r), .hbyte(hdr_byte), .hdc(hdr_dc)
  );

  assign in_hdr    = (state == ST_HDR);
  assign in_pix    = (state == ST_PIX);
  assign req_ready = (state == ST_IDLE) && rst_n;
  assign accept    = req_valid && req_ready;
  assign start     = accept && !empty_c;

  dws_pixel_stage u_pix (
    .clk(clk), .rst_n(rst_n), .start(start), .npix(npix_c),
    .blank(req_blank), .swap(swap_en), .active(in_pix),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
    .byte_valid(pix_bvalid), .byte_ready(out_ready), .byte_out(pix_byte),
    .last_fire(last_fire)
  );

  assign out_valid = in_hdr || pix_bvalid;
  assign out_byte  = in_hdr ? hdr_byte : pix_byte;
  assign out_dc    = in_hdr ? hdr_dc : 1'b1;
  assign done      = done_r;
  assign err       = err_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      hdr_idx <= '0;
      win_r   <= '0;
      done_r  <= 1'b0;
      err_r   <= 1'b0;
    end else begin
      done_r <= 1'b0;
      err_r  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (empty_c) begin
              err_r <= 1'b1;
            end else begin
              win_r   <= win_c;
              hdr_idx <= '0;
              state   <= ST_HDR;
            end
          end
        end
        ST_HDR: begin
          if (out_ready) begin
            if (hdr_idx == 4'(HDR_LAST)) state <= ST_PIX;
            else hdr_idx <= hdr_idx + 4'd1;
          end
        end
        ST_PIX: begin
          if (last_fire) begin
            state  <= ST_IDLE;
            done_r <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_dc)));

  // R9
  done_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(out_valid && out_ready) && !out_valid));

  // R8
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!out_valid && !done && !pix_ready));

  // R3
  cmd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_dc) |-> (out_byte == CMD_COLUMN || out_byte == CMD_ROW ||
                                out_byte == CMD_MEMWR));

  // R2
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || pix_ready) |-> !req_ready);
endmodule

// File: tb/tb_disp_window_seq.sv
module tb_disp_window_seq;
  localparam int PW = 6;
  localparam int PH = 4;
  localparam int LO = 252;
  localparam int TO = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_blank = 1'b0, swap_en = 1'b0;
  logic [15:0] req_x0 = '0, req_y0 = '0, req_x1 = '0, req_y1 = '0;
  logic pix_valid = 1'b0, out_ready = 1'b0;
  logic [15:0] pix_data = '0;
  logic req_ready, pix_ready, out_valid, out_dc, done, err;
  logic [7:0] out_byte;

  always #2.5 clk = ~clk;

  disp_window_seq #(.PANEL_W(PW), .PANEL_H(PH), .LEFT_OFS(LO), .TOP_OFS(TO)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_x0(req_x0), .req_y0(req_y0), .req_x1(req_x1), .req_y1(req_y1),
    .req_blank(req_blank), .swap_en(swap_en), .pix_valid(pix_valid),
    .pix_ready(pix_ready), .pix_data(pix_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_byte(out_byte), .out_dc(out_dc),
    .done(done), .err(err)
  );

  int checks = 0, failures = 0;
  logic [9:0] exp_q[$];
  string      exp_tag[$];
  int src_idx = 0, exp_pix = 0, issued = 0, done_cnt = 0;
  bit pfire = 0, done_due = 0, bad_mode = 0, blank_mode = 0, run_on = 0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [15:0] pix_fn(int i);
    return {8'(i * 3 + 1), 8'(i ^ 8'hC6)};
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, expv);
    end
  endtask

  task automatic put(logic [7:0] b, logic dc, bit last, string tag);
    exp_q.push_back({last, dc, b});
    exp_tag.push_back(tag);
  endtask

  task automatic push_exp(int x0, int y0, int x1, int y1, bit blk, bit swp);
    logic [15:0] xs, xe, ys, ye, v;
    int n;
    if (blk) begin x0 = 0; y0 = 0; x1 = PW; y1 = PH; end
    xs = 16'(x0 + LO); xe = 16'(x1 - 1 + LO);
    ys = 16'(y0 + TO); ye = 16'(y1 - 1 + TO);
    put(8'h2A, 0, 0, "R3");
    put(xs[15:8], 1, 0, "R4"); put(xs[7:0], 1, 0, "R4");
    put(xe[15:8], 1, 0, "R4"); put(xe[7:0], 1, 0, "R4");
    put(8'h2B, 0, 0, "R3");
    put(ys[15:8], 1, 0, "R4"); put(ys[7:0], 1, 0, "R4");
    put(ye[15:8], 1, 0, "R4"); put(ye[7:0], 1, 0, "R4");
    put(8'h2C, 0, 0, "R3");
    n = (x1 - x0) * (y1 - y0);
    for (int k = 0; k < n; k++) begin
      if (blk) v = 16'h0000;
      else begin v = pix_fn(exp_pix); exp_pix++; end
      if (swp) begin
        put(v[7:0], 1, 0, blk ? "R7" : "R6");
        put(v[15:8], 1, k == n - 1, blk ? "R7" : "R6");
      end else begin
        put(v[15:8], 1, 0, blk ? "R7" : "R5");
        put(v[7:0], 1, k == n - 1, blk ? "R7" : "R5");
      end
    end
  endtask

  // stimulus for the pixel source and output back-pressure
  always @(posedge clk) begin
    #1;
    if (pfire) src_idx++;
    pix_data = pix_fn(src_idx);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (!(pix_valid && !pfire)) pix_valid = run_on && (lfsr[2:1] != 2'b00);
    out_ready = run_on && (lfsr[5:4] != 2'b00 || lfsr[9]);
  end

  // monitor, sampled away from the clock edge
  always @(negedge clk) begin
    bit due_next;
    logic [9:0] e;
    string t;
    due_next = 0;
    pfire = pix_valid && pix_ready;
    if (rst_n) begin
      if (done || done_due)
        chk(done == done_due, "R9", "done pulse timing", done, done_due);
      if (done) done_cnt++;
      if (err && !bad_mode) chk(0, "R8", "unexpected err", 1, 0);
      if (blank_mode && pix_ready) chk(0, "R7", "pix_ready during blank", 1, 0);
      if (req_valid && req_ready && exp_q.size() != 0)
        chk(0, "R2", "request accepted while busy", exp_q.size(), 0);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk(0, "R5", "unexpected byte", {out_dc, out_byte}, 0);
        else begin
          e = exp_q.pop_front();
          t = exp_tag.pop_front();
          chk({out_dc, out_byte} == e[8:0], t, "output byte/flag", {out_dc, out_byte}, e[8:0]);
          if (e[9]) due_next = 1;
        end
      end
    end
    done_due = due_next;
  end

  task automatic drive(int x0, int y0, int x1, int y1, bit blk, bit swp);
    @(posedge clk); #1;
    req_x0 = 16'(x0); req_y0 = 16'(y0); req_x1 = 16'(x1); req_y1 = 16'(y1);
    req_blank = blk; swap_en = swp; req_valid = 1'b1;
    forever begin @(negedge clk); if (req_ready) break; end
    @(posedge clk); #1;
    req_valid = 1'b0;
    swap_en = ~swp;
  endtask

  task automatic do_req(int x0, int y0, int x1, int y1, bit blk, bit swp, bit wait_all);
    drive(x0, y0, x1, y1, blk, swp);
    push_exp(x0, y0, x1, y1, blk, swp);
    issued++;
    if (wait_all) while (done_cnt < issued) @(negedge clk);
  endtask

  task automatic do_bad(int x0, int y0, int x1, int y1);
    int s;
    bad_mode = 1;
    drive(x0, y0, x1, y1, 0, 0);
    s = src_idx;
    @(negedge clk);
    chk(err == 1'b1, "R8", "err pulse after reject", err, 1);
    chk(out_valid == 1'b0, "R8", "no byte on reject", out_valid, 0);
    repeat (4) begin
      @(negedge clk);
      chk(!out_valid && !err, "R8", "quiet after reject", {out_valid, err}, 0);
    end
    chk(src_idx == s, "R8", "no pixel consumed", src_idx, s);
    chk(req_ready == 1'b1, "R2", "ready after reject", req_ready, 1);
    bad_mode = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({out_valid, done, err, pix_ready} == 4'b0, "R1", "outputs in reset",
        {out_valid, done, err, pix_ready}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
    chk(pix_ready == 1'b0, "R11", "pix_ready idle", pix_ready, 0);
    run_on = 1;
    // near-exhaustive sweep of regions in the small panel, both byte orders
    for (int x0 = 0; x0 < PW; x0++)
      for (int x1 = x0 + 1; x1 <= PW; x1++)
        for (int y0 = 0; y0 < PH; y0++)
          for (int y1 = y0 + 1; y1 <= PH; y1++)
            do_req(x0, y0, x1, y1, 0, 1'((x0 + y0 + x1) & 1), 1);
    // blank: coordinates ignored, zero payload, no pixel pulls (R7)
    begin
      int s;
      s = src_idx;
      blank_mode = 1;
      do_req(3, 3, 3, 1, 1, 0, 1);
      do_req(0, 0, 0, 0, 1, 1, 1);
      blank_mode = 0;
      chk(src_idx == s, "R7", "blank consumed no pixel", src_idx, s);
    end
    // zero-area rejections (R8)
    do_bad(2, 0, 2, 3);
    do_bad(0, 3, 4, 1);
    do_bad(5, 1, 1, 2);
    // back-to-back: second request waits while first is streaming (R2)
    do_req(0, 0, PW, PH, 0, 0, 0);
    do_req(1, 1, 3, 2, 0, 1, 1);
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R5", "all expected bytes seen", exp_q.size(), 0);
    chk(done_cnt == issued, "R9", "done count", done_cnt, issued);
    chk(src_idx == exp_pix, "R11", "pixels consumed", src_idx, exp_pix);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", done_cnt, issued);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule